// File: doc/BRIEF.md
# Accumulator ALU with Opcode Decode

This block is the execute stage of a small 8-bit processor. One input beat carries a single opcode byte, the current accumulator, an operand byte that was already fetched (from a register, from memory or from the byte after the opcode), and the current five flags. The block decodes the opcode and computes the new accumulator and the new flags. It covers subtract, subtract with borrow, compare, AND, XOR and OR in both the register/memory form and the immediate form. It also covers the four single-bit accumulator rotates, accumulator complement, the two carry-only operations and decimal adjust.

Each result beat also carries a source descriptor: what kind of operand the opcode names and which register field it selected. The surrounding sequencer uses this descriptor to fetch the operand. The beat also carries the nominal number of clock states the operation takes. An opcode outside this set is still accepted. It yields a beat marked not-ok that passes the accumulator and flags through unchanged.

Both sides are valid/ready streams with one output register. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. A result stays on the output, unchanged, until a clock edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being emptied in that cycle, so one beat per cycle flows when the consumer never stalls.

Top module: `acc_alu`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A beat accepted on an edge appears on the outputs after that edge. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R2: For opcodes `10 ooo sss`, `out_src_reg` equals sss. `out_src_kind` is 1 (register) unless sss=110, in which case it is 2 (memory). Immediate forms give kind 3 and reg 0. Rotate and special opcodes give kind 0 and reg 0. The register codes are B=000, C=001, D=010, E=011, H=100, L=101, A=111.
- R3: ooo selects the operation: 010 subtract, 011 subtract with borrow, 100 AND, 101 XOR, 110 OR, 111 compare. Compare sets the flags exactly as subtract does but returns the accumulator unchanged.
- R4: Subtract with borrow computes A − operand − CY. CY is set when the true difference is negative.
- R5: The flags vector is [4]=S, [3]=Z, [2]=AC, [1]=P, [0]=CY. For subtract, subtract with borrow and compare: S is bit 7 of the difference, Z is set when the difference is zero, and P is set when the difference has an even number of ones. AC is set when the low-nibble difference (including borrow) is negative. CY is the borrow out of bit 7.
- R6: AND, XOR and OR clear CY and AC and set S, Z and P from the result.
- R7: Immediate forms `11 ooo 110` perform the same operation as the register form with the same ooo, using the operand byte.
- R8: `out_cycles` is 4 for register operands and for rotate and special opcodes. It is 7 for memory operands (sss=110) and for immediate forms.
- R9: 00000111 rotates left with bit 7 into CY and bit 0. 00001111 rotates right with bit 0 into CY and bit 7. 00010111 rotates left through CY. 00011111 rotates right through CY. Only CY changes among the flags.
- R10: 00101111 complements A and leaves all flags unchanged. 00110111 sets CY. 00111111 inverts CY. The last two leave A and the other flags unchanged.
- R11: 00100111 (decimal adjust) first adds 06h when the low nibble exceeds 9 or AC is set. AC then becomes the carry out of bit 3 of that addition. It next adds 60h when the high nibble of the intermediate value exceeds 9, or CY is set, or the first addition carried out of bit 7. CY becomes 1 exactly when that second addition is applied. S, Z and P follow the final value.
- R12: Any other opcode yields `out_ok`=0, the input accumulator and flags unchanged, `out_cycles`=0, and kind 0 with reg 0. All recognised opcodes yield `out_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_opcode | input | 8 | Opcode byte |
| in_acc | input | 8 | Current accumulator |
| in_operand | input | 8 | Fetched operand byte |
| in_flags | input | 5 | Current flags {S,Z,AC,P,CY} |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_ok | output | 1 | Opcode was recognised |
| out_acc | output | 8 | New accumulator |
| out_flags | output | 5 | New flags {S,Z,AC,P,CY} |
| out_src_kind | output | 2 | 0 none, 1 register, 2 memory, 3 immediate |
| out_src_reg | output | 3 | Selected register field |
| out_cycles | output | CYC_W | Nominal clock states |

## Verification
Subtract with borrow is tested with CY both clear and set at the edges of the range, including 00h − FFh − 1 and equal operands. A design that ignores the incoming borrow, or that takes CY from bit 8 of a truncated sum, gets the accumulator or CY wrong there. Decimal adjust is tested on values where neither, one or both corrections apply, and where only an incoming AC or CY triggers them. A design that checks the high nibble before the first correction, or that clears CY when no correction applies, gives a different byte or carry. Compare and complement are checked for leaving the accumulator and the flags alone respectively. Unrecognised opcodes next to valid ones, such as the ooo=000 row and an immediate form with sss other than 110, must come back not-ok and untouched. A consumer that stalls in a random pattern tests that results are neither lost, repeated nor changed while held.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int DATA_W = 8;
  localparam int FLAG_W = 5;

  typedef enum logic [3:0] {
    OP_SUB, OP_SBB, OP_AND, OP_XOR, OP_OR, OP_CMP,
    OP_RLC, OP_RRC, OP_RAL, OP_RAR,
    OP_CMA, OP_STC, OP_CMC, OP_DAA, OP_BAD
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REG  = 2'd1,
    SRC_MEM  = 2'd2,
    SRC_IMM  = 2'd3
  } src_kind_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  localparam logic [2:0] SSS_MEM = 3'b110;

  function automatic alu_op_e group_op(input logic [2:0] ooo);
    case (ooo)
      3'b010:  group_op = OP_SUB;
      3'b011:  group_op = OP_SBB;
      3'b100:  group_op = OP_AND;
      3'b101:  group_op = OP_XOR;
      3'b110:  group_op = OP_OR;
      3'b111:  group_op = OP_CMP;
      default: group_op = OP_BAD;
    endcase
  endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_alu_pkg::*;
#(
  parameter int CYC_W      = 4,
  parameter int REG_STATES = 4,
  parameter int MEM_STATES = 7
) (
  input  logic [7:0]       opcode,
  output alu_op_e          op,
  output src_kind_e        kind,
  output logic [2:0]       src_reg,
  output logic [CYC_W-1:0] cycles
);

  localparam logic [CYC_W-1:0] CYC_SHORT = CYC_W'(REG_STATES);
  localparam logic [CYC_W-1:0] CYC_LONG  = CYC_W'(MEM_STATES);

  logic [2:0] ooo;
  logic [2:0] sss;
  assign ooo = opcode[5:3];
  assign sss = opcode[2:0];

  always_comb begin
    op      = OP_BAD;
    kind    = SRC_NONE;
    src_reg = 3'b000;
    cycles  = '0;
    if (opcode[7:6] == 2'b10) begin
      op = group_op(ooo);
      if (op != OP_BAD) begin
        src_reg = sss;
        kind    = (sss == SSS_MEM) ? SRC_MEM : SRC_REG;
        cycles  = (sss == SSS_MEM) ? CYC_LONG : CYC_SHORT;
      end
    end else if (opcode[7:6] == 2'b11 && sss == SSS_MEM) begin
      op = group_op(ooo);
      if (op != OP_BAD) begin
        kind   = SRC_IMM;
        cycles = CYC_LONG;
      end
    end else if (opcode[7:6] == 2'b00 && sss == 3'b111) begin
      cycles = CYC_SHORT;
      case (ooo)
        3'b000:  op = OP_RLC;
        3'b001:  op = OP_RRC;
        3'b010:  op = OP_RAL;
        3'b011:  op = OP_RAR;
        3'b100:  op = OP_DAA;
        3'b101:  op = OP_CMA;
        3'b110:  op = OP_STC;
        default: op = OP_CMC;
      endcase
    end
  end

endmodule

// File: rtl/acc_exec.sv
module acc_exec
  import acc_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] x,
  input  flags_t            f_in,
  output logic [DATA_W-1:0] res,
  output flags_t            f_out
);

  logic       bin;
  logic [8:0] diff;
  logic [4:0] ldiff;
  logic       lo_fix;
  logic       hi_fix;
  logic [4:0] lsum;
  logic [8:0] s1;
  logic [7:0] daa_val;

  assign bin   = (op == OP_SBB) ? f_in.cy : 1'b0;
  assign diff  = {1'b0, a} - {1'b0, x} - {8'd0, bin};
  assign ldiff = {1'b0, a[3:0]} - {1'b0, x[3:0]} - {4'd0, bin};

  assign lo_fix  = (a[3:0] > 4'd9) || f_in.ac;
  assign lsum    = {1'b0, a[3:0]} + (lo_fix ? 5'd6 : 5'd0);
  assign s1      = {1'b0, a} + (lo_fix ? 9'h006 : 9'h000);
  assign hi_fix  = (s1[7:4] > 4'd9) || f_in.cy || s1[8];
  assign daa_val = s1[7:0] + (hi_fix ? 8'h60 : 8'h00);

  function automatic flags_t szp(input logic [7:0] v, input logic ac, input logic cy);
    flags_t t;
    t.s  = v[7];
    t.z  = (v == 8'h00);
    t.ac = ac;
    t.p  = ~^v;
    t.cy = cy;
    return t;
  endfunction

  always_comb begin
    res   = a;
    f_out = f_in;
    case (op)
      OP_SUB, OP_SBB: begin
        res   = diff[7:0];
        f_out = szp(diff[7:0], ldiff[4], diff[8]);
      end
      OP_CMP: f_out = szp(diff[7:0], ldiff[4], diff[8]);
      OP_AND: begin res = a & x; f_out = szp(a & x, 1'b0, 1'b0); end
      OP_XOR: begin res = a ^ x; f_out = szp(a ^ x, 1'b0, 1'b0); end
      OP_OR:  begin res = a | x; f_out = szp(a | x, 1'b0, 1'b0); end
      OP_RLC: begin res = {a[6:0], a[7]};    f_out.cy = a[7]; end
      OP_RRC: begin res = {a[0], a[7:1]};    f_out.cy = a[0]; end
      OP_RAL: begin res = {a[6:0], f_in.cy}; f_out.cy = a[7]; end
      OP_RAR: begin res = {f_in.cy, a[7:1]}; f_out.cy = a[0]; end
      OP_CMA: res = ~a;
      OP_STC: f_out.cy = 1'b1;
      OP_CMC: f_out.cy = ~f_in.cy;
      OP_DAA: begin
        res   = daa_val;
        f_out = szp(daa_val, lsum[4], hi_fix);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int CYC_W      = 4,
  parameter int REG_STATES = 4,
  parameter int MEM_STATES = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_opcode,
  input  logic [7:0]       in_acc,
  input  logic [7:0]       in_operand,
  input  logic [4:0]       in_flags,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_ok,
  output logic [7:0]       out_acc,
  output logic [4:0]       out_flags,
  output logic [1:0]       out_src_kind,
  output logic [2:0]       out_src_reg,
  output logic [CYC_W-1:0] out_cycles
);

  alu_op_e          d_op;
  src_kind_e        d_kind;
  logic [2:0]       d_reg;
  logic [CYC_W-1:0] d_cyc;
  logic [7:0]       e_res;
  flags_t           e_flags;

  acc_decode #(
    .CYC_W(CYC_W), .REG_STATES(REG_STATES), .MEM_STATES(MEM_STATES)
  ) u_dec (
    .opcode (in_opcode),
    .op     (d_op),
    .kind   (d_kind),
    .src_reg(d_reg),
    .cycles (d_cyc)
  );

  acc_exec u_exe (
    .op   (d_op),
    .a    (in_acc),
    .x    (in_operand),
    .f_in (flags_t'(in_flags)),
    .res  (e_res),
    .f_out(e_flags)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_ok       <= 1'b0;
      out_acc      <= '0;
      out_flags    <= '0;
      out_src_kind <= '0;
      out_src_reg  <= '0;
      out_cycles   <= '0;
    end else if (in_valid && in_ready) begin
      out_valid    <= 1'b1;
      out_ok       <= (d_op != OP_BAD);
      out_acc      <= e_res;
      out_flags    <= e_flags;
      out_src_kind <= d_kind;
      out_src_reg  <= d_reg;
      out_cycles   <= d_cyc;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int CYC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_opcode,
  input logic [7:0]       in_acc,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_ok,
  input logic [7:0]       out_acc,
  input logic [4:0]       out_flags,
  input logic [1:0]       out_src_kind,
  input logic [2:0]       out_src_reg,
  input logic [CYC_W-1:0] out_cycles
);

  logic take;
  assign take = in_valid && in_ready;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_acc) && $stable(out_flags)
                                   && $stable(out_ok) && $stable(out_cycles)));

  p_mem_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_src_kind == 2'd2) |-> (out_src_reg == 3'b110));

  p_cmp_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_opcode[7] && in_opcode[5:3] == 3'b111
     && (!in_opcode[6] || in_opcode[2:0] == 3'b110)) |=> (out_acc == $past(in_acc)));

  p_logic_cy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_opcode[7] && in_opcode[5] && !(in_opcode[4] && in_opcode[3])
     && (!in_opcode[6] || in_opcode[2:0] == 3'b110)) |=> (out_flags[0] == 1'b0 && out_flags[2] == 1'b0));

  p_cycles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ok) |-> (out_cycles == CYC_W'(4) || out_cycles == CYC_W'(7)));

  p_bad_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ok) |-> (out_cycles == '0 && out_src_kind == 2'd0 && out_src_reg == 3'd0));

endmodule

bind acc_alu acc_alu_chk #(.CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .in_acc(in_acc), .out_valid(out_valid),
  .out_ready(out_ready), .out_ok(out_ok), .out_acc(out_acc),
  .out_flags(out_flags), .out_src_kind(out_src_kind),
  .out_src_reg(out_src_reg), .out_cycles(out_cycles)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

  typedef struct packed {
    logic       ok;
    logic [7:0] acc;
    logic [4:0] flags;
    logic [1:0] kind;
    logic [2:0] rsel;
    logic [3:0] cyc;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_opcode = '0;
  logic [7:0] in_acc = '0;
  logic [7:0] in_operand = '0;
  logic [4:0] in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_ok;
  logic [7:0] out_acc;
  logic [4:0] out_flags;
  logic [1:0] out_src_kind;
  logic [2:0] out_src_reg;
  logic [3:0] out_cycles;

  int    n_run = 0;
  int    n_fail = 0;
  int    mode = 0;
  int    cyc_cnt = 0;
  logic [7:0] lfsr = 8'hA5;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_acc(in_acc), .in_operand(in_operand),
    .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_ok(out_ok), .out_acc(out_acc), .out_flags(out_flags),
    .out_src_kind(out_src_kind), .out_src_reg(out_src_reg),
    .out_cycles(out_cycles)
  );

  function automatic logic [4:0] mkf(input logic [7:0] v, input logic ac, input logic cy);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(v[i]);
    return {v[7], v == 8'h00, ac, (ones % 2) == 0, cy};
  endfunction

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] a,
                                 input logic [7:0] x, input logic [4:0] f);
    exp_t e;
    int ooo = int'(op[5:3]);
    int sss = int'(op[2:0]);
    int ai = int'(a);
    int xi = int'(x);
    e = '{ok: 1'b0, acc: a, flags: f, kind: 2'd0, rsel: 3'd0, cyc: 4'd0};
    if (ooo >= 2 && (op[7:6] == 2'b10 || (op[7:6] == 2'b11 && sss == 6))) begin
      int b = (ooo == 3) ? int'(f[0]) : 0;
      int d = ai - xi - b;
      int dl = (ai % 16) - (xi % 16) - b;
      logic [7:0] r;
      e.ok = 1'b1;
      if (op[6]) begin e.kind = 2'd3; e.cyc = 4'd7; end
      else begin
        e.rsel = op[2:0];
        e.kind = (sss == 6) ? 2'd2 : 2'd1;
        e.cyc  = (sss == 6) ? 4'd7 : 4'd4;
      end
      if (ooo == 4)      begin r = a & x; e.flags = mkf(r, 1'b0, 1'b0); end
      else if (ooo == 5) begin r = a ^ x; e.flags = mkf(r, 1'b0, 1'b0); end
      else if (ooo == 6) begin r = a | x; e.flags = mkf(r, 1'b0, 1'b0); end
      else begin
        r = 8'((d + 256) % 256);
        e.flags = mkf(r, dl < 0, d < 0);
      end
      e.acc = (ooo == 7) ? a : r;
    end else if (op[7:6] == 2'b00 && sss == 7) begin
      e.ok = 1'b1;
      e.cyc = 4'd4;
      case (ooo)
        0: begin e.acc = 8'((ai * 2) % 256 + ai / 128); e.flags[0] = a[7]; end
        1: begin e.acc = 8'(ai / 2 + (ai % 2) * 128);   e.flags[0] = a[0]; end
        2: begin e.acc = 8'((ai * 2) % 256 + int'(f[0])); e.flags[0] = a[7]; end
        3: begin e.acc = 8'(ai / 2 + int'(f[0]) * 128);  e.flags[0] = a[0]; end
        4: begin
          int v = ai;
          int hi;
          logic acn = 1'b0;
          logic cyn = 1'b0;
          if ((ai % 16) > 9 || f[2]) begin
            acn = ((ai % 16) + 6) > 15;
            v = v + 6;
          end
          hi = (v % 256) / 16;
          if (hi > 9 || f[0] || v > 255) begin v = v + 96; cyn = 1'b1; end
          e.acc = 8'(v % 256);
          e.flags = mkf(e.acc, acn, cyn);
        end
        5: e.acc = 8'(255 - ai);
        6: e.flags[0] = 1'b1;
        default: e.flags[0] = ~f[0];
      endcase
    end
    return e;
  endfunction

  task automatic send(input string tag, input logic [7:0] op, input logic [7:0] a,
                      input logic [7:0] x, input logic [4:0] f);
    logic acc_now;
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_acc = a; in_operand = x; in_flags = f;
    forever begin
      #4;
      acc_now = in_ready;
      @(posedge clk);
      if (acc_now) break;
      @(negedge clk);
    end
    exp_q.push_back(model(op, a, x, f));
    tag_q.push_back(tag);
    #1 in_valid = 1'b0;
  endtask

  task automatic check(input string tag, input logic cond, input string what,
                       input int act, input int expv);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0];
      default: out_ready = 1'b0;
    endcase
  end

  initial begin : monitor
    exp_t  e;
    string t;
    exp_t  got;
    forever begin
      @(negedge clk);
      #4;
      if (rst_n && out_valid && out_ready) begin
        got = '{ok: out_ok, acc: out_acc, flags: out_flags, kind: out_src_kind,
                rsel: out_src_reg, cyc: out_cycles};
        if (exp_q.size() == 0) begin
          check("R1", 1'b0, "unexpected beat", int'(got), 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, got == e, "result", int'(got), int'(e));
        end
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 50000) begin
        n_run++; n_fail++;
        $display("FAIL R1 watchdog expired: actual %0d expected below 50000", cyc_cnt);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_valid == 1'b0, "reset out_valid", int'(out_valid), 0);
    check("R1", in_ready == 1'b1, "reset in_ready", int'(in_ready), 1);

    // R2 R8: every source code on subtract
    for (int s = 0; s < 8; s++)
      send("R2_R8", {5'b10010, 3'(s)}, 8'h10 + 8'(s), 8'h20, 5'b00000);
    // R3 R5: subtract and compare
    send("R3_R5", 8'h90, 8'h10, 8'h20, 5'b00000);
    send("R3_R5", 8'h97, 8'h42, 8'h42, 5'b00001);
    send("R3", 8'hB8, 8'h30, 8'h31, 5'b00000);
    send("R3", 8'hBE, 8'h80, 8'h01, 5'b11111);
    // R4: borrow edges
    send("R4", 8'h98, 8'h00, 8'hFF, 5'b00001);
    send("R4", 8'h9F, 8'h55, 8'h55, 5'b00001);
    send("R4", 8'h99, 8'h55, 8'h54, 5'b00001);
    send("R4", 8'h9A, 8'h55, 8'h54, 5'b00000);
    // R6: logical ops
    send("R6", 8'hA0, 8'hF0, 8'h0F, 5'b00101);
    send("R6", 8'hAE, 8'hC3, 8'h81, 5'b00101);
    send("R6", 8'hA9, 8'h5A, 8'h5A, 5'b00101);
    send("R6", 8'hB1, 8'h00, 8'h00, 5'b00101);
    send("R6", 8'hB7, 8'h12, 8'h34, 5'b00101);
    // R7: immediate forms
    send("R7", 8'hD6, 8'h05, 8'h07, 5'b00000);
    send("R7", 8'hDE, 8'h05, 8'h05, 5'b00001);
    send("R7", 8'hE6, 8'hFF, 8'h3C, 5'b00001);
    send("R7", 8'hEE, 8'hAA, 8'hFF, 5'b00000);
    send("R7", 8'hF6, 8'h01, 8'h80, 5'b00001);
    send("R7", 8'hFE, 8'h40, 8'h41, 5'b00000);
    // R9: rotates
    send("R9", 8'h07, 8'h81, 8'h00, 5'b11100);
    send("R9", 8'h0F, 8'h81, 8'h00, 5'b11100);
    send("R9", 8'h17, 8'h40, 8'h00, 5'b00001);
    send("R9", 8'h1F, 8'h02, 8'h00, 5'b00001);
    send("R9", 8'h1F, 8'h01, 8'h00, 5'b01010);
    // R10: complement and carry ops
    send("R10", 8'h2F, 8'h3C, 8'h00, 5'b10101);
    send("R10", 8'h37, 8'h3C, 8'h00, 5'b01010);
    send("R10", 8'h3F, 8'h3C, 8'h00, 5'b01011);
    send("R10", 8'h3F, 8'h3C, 8'h00, 5'b01010);
    // R11: decimal adjust
    send("R11", 8'h27, 8'h9B, 8'h00, 5'b00000);
    send("R11", 8'h27, 8'h99, 8'h00, 5'b00000);
    send("R11", 8'h27, 8'h00, 8'h00, 5'b00101);
    send("R11", 8'h27, 8'h45, 8'h00, 5'b00000);
    send("R11", 8'h27, 8'hA0, 8'h00, 5'b00000);
    send("R11", 8'h27, 8'h9A, 8'h00, 5'b00000);
    // R12: unrecognised
    send("R12", 8'h80, 8'h12, 8'h34, 5'b10101);
    send("R12", 8'hCE, 8'h12, 8'h34, 5'b01010);
    send("R12", 8'hD7, 8'h12, 8'h34, 5'b00001);
    send("R12", 8'h00, 8'h77, 8'h34, 5'b11111);
    send("R12", 8'h8E, 8'h77, 8'h34, 5'b00000);
    drain();

    // R1: random back-pressure
    mode = 1;
    for (int i = 0; i < 40; i++)
      send("R1", 8'h90 + 8'(i % 48), 8'(i * 37), 8'(i * 11 + 3), 5'(i));
    drain();

    // R1: held result under full stall
    mode = 2;
    @(negedge clk);
    send("R1", 8'hE6, 8'hF3, 8'h5C, 5'b00001);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #4;
      check("R1", out_valid && !in_ready && out_acc == 8'h50, "stall hold",
            int'({out_valid, in_ready, out_acc}), int'({1'b1, 1'b0, 8'h50}));
    end
    mode = 0;
    drain();
    repeat (3) @(negedge clk);
    check("R1", out_valid == 1'b0, "drained", int'(out_valid), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule